// File: doc/BRIEF.md
# External Byte-Wide Memory Bus Controller

This block turns single-beat requests from an internal port into timed cycles on an external 8-bit memory bus. Three devices share the bus: an SRAM, a Flash device and one small extra peripheral. Each request names a source (the internal processor port or the host-side path), a target, a 17-bit address, a direction and, for writes, one data byte. The controller drives the address, one active-low chip enable, an active-low output enable, an active-low write enable and the data bus with its driver enable. It then reports completion with a one-cycle done pulse. Read data is returned on that pulse.

Write cycles are sequenced so that the address and data are set up before the write strobe falls and stay valid past the strobe's rising edge. Read cycles hold the output enable for a fixed number of clocks and sample the data bus at the end of that window. The extra peripheral decodes only the low four address bits and may only be reached from the internal port. A host-side request for it completes at once with an error and touches no pin of the bus.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: During and right after reset, all three chip enables, the output enable and the write enable are high, the data driver enable is low, rsp_done is low and req_ready is high.
- R2: A write is accepted on the clock edge where req_valid and req_ready are both high. In the 1st following cycle the chip enable is low, the write enable is high and the data driver is on. In the 2nd and 3rd cycles the write enable is low. In the 4th cycle the write enable is high again while the chip enable and data stay active. In the 5th cycle everything is released and rsp_done is high with rsp_err low.
- R3: Throughout a write cycle, mem_addr and mem_dout hold the request's mapped address and data without change. A value written is the value later read back from the same device and address.
- R4: A read drives the chip enable and output enable low, with the data driver off, for the 1st and 2nd cycles after acceptance. mem_din is sampled at the end of the 2nd cycle. In the 3rd cycle the enables are high, rsp_done is high and rsp_rdata carries the sampled byte.
- R5: The output enable and write enable are never low together, and the data driver is never on while the output enable is low, including on a write that directly follows a read.
- R6: At most one chip enable is low at any time. The target code selects the device: 0 is the SRAM, 1 is the Flash, 2 is the extra peripheral and 3 is reserved.
- R7: SRAM and Flash accesses place all 17 request address bits on mem_addr. The two devices are separate, so the same address in each holds its own byte.
- R8: An internal-port (req_host=0) request with target 2 asserts mem_xdev_n. mem_addr is then formed from the low four request bits, and every higher bit is zero whatever the request carried.
- R9: A request with req_host=1 and target 2, or any request with target 3, gives rsp_done with rsp_err high in the 1st cycle after acceptance. No chip enable goes low and the data driver stays off.
- R10: req_ready is low for the whole of an access. A request presented while req_ready is low is ignored and produces no later bus cycle and no response.
- R11: rsp_rdata changes only when a read completes, so it keeps the last read byte across writes and error responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_host | input | 1 | 1 = host-side path, 0 = internal port |
| req_tgt | input | 2 | Target: 0 SRAM, 1 Flash, 2 peripheral, 3 reserved |
| req_addr | input | 17 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a refused request |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | External address bus |
| mem_sram_n | output | 1 | SRAM chip enable, active low |
| mem_flash_n | output | 1 | Flash chip enable, active low |
| mem_xdev_n | output | 1 | Extra peripheral enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 8 | Data bus outgoing value, bit 7 MSB |
| mem_dout_en | output | 1 | Data bus driver enable |
| mem_din | input | 8 | Data bus incoming value |

## Verification
The bench goes after the strobe timing on every write. A controller that drops the write enable in the same cycle as the chip enable, or releases data before the strobe rises, shows up in the per-cycle checks, and the memory model, which latches on the strobe's rising edge, then reads back a wrong byte. A read directly followed by a write probes bus contention: turning the driver on while the output enable is still low would trip the overlap check. Host requests to the peripheral and to the reserved code must return an error without a chip enable. The same peripheral address issued from the internal port must reach the device with its upper bits cleared, or the read-back would miss. A request pushed in while the block is busy must vanish; a design that queued it would raise an unexpected done.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   typedef enum logic [1:0] {
      TGT_SRAM  = 2'd0,
      TGT_FLASH = 2'd1,
      TGT_XDEV  = 2'd2,
      TGT_RSVD  = 2'd3
   } xmb_tgt_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WSET = 3'd1,
      ST_WSTB = 3'd2,
      ST_WREL = 3'd3,
      ST_RACT = 3'd4
   } xmb_state_e;

   localparam int unsigned NUM_CE   = 3;
   localparam int unsigned CE_SRAM  = 0;
   localparam int unsigned CE_FLASH = 1;
   localparam int unsigned CE_XDEV  = 2;

endpackage

// File: rtl/xmb_decode.sv
module xmb_decode
   import xmb_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned WIN_W  = 4
) (
   input  logic                  host,
   input  logic [1:0]            tgt,
   input  logic [ADDR_W-1:0]     addr,
   output logic [NUM_CE-1:0]     sel,
   output logic                  bad,
   output logic [ADDR_W-1:0]     map_addr
);

   logic [ADDR_W-1:0] win_addr;

   generate
      if (WIN_W < ADDR_W) begin : g_win_narrow
         localparam int unsigned PAD_W = ADDR_W - WIN_W;
         assign win_addr = {{PAD_W{1'b0}}, addr[WIN_W-1:0]};
      end else begin : g_win_full
         assign win_addr = addr;
      end
   endgenerate

   always_comb begin
      sel      = '0;
      bad      = 1'b0;
      map_addr = addr;
      case (xmb_tgt_e'(tgt))
         TGT_SRAM:  sel[CE_SRAM]  = 1'b1;
         TGT_FLASH: sel[CE_FLASH] = 1'b1;
         TGT_XDEV: begin
            map_addr = win_addr;
            if (host) bad = 1'b1;
            else      sel[CE_XDEV] = 1'b1;
         end
         default:   bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
   import xmb_pkg::*;
#(
   parameter int unsigned RD_CYCLES  = 2,
   parameter int unsigned WR_STROBES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_we,
   input  logic req_bad,
   output logic req_ready,
   output logic load,
   output logic capture,
   output logic ce_act,
   output logic oe_act,
   output logic we_act,
   output logic drv_act,
   output logic done_q,
   output logic err_q
);

   localparam int unsigned CNT_MAX = (RD_CYCLES > WR_STROBES) ? RD_CYCLES : WR_STROBES;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (RD_CYCLES < 1) begin : g_chk_rd
         $error("xmb_seq: RD_CYCLES must be at least 1");
      end
      if (WR_STROBES < 1) begin : g_chk_wr
         $error("xmb_seq: WR_STROBES must be at least 1");
      end
   endgenerate

   xmb_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             done_d, err_d;
   logic             idle;

   assign idle      = (state_q == ST_IDLE);
   assign req_ready = idle;
   assign load      = idle & req_valid & ~req_bad;
   assign capture   = (state_q == ST_RACT) && (cnt_q == '0);

   assign ce_act  = ~idle;
   assign oe_act  = (state_q == ST_RACT);
   assign we_act  = (state_q == ST_WSTB);
   assign drv_act = (state_q == ST_WSET) || (state_q == ST_WSTB) || (state_q == ST_WREL);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      done_d  = 1'b0;
      err_d   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (req_bad) begin
                  done_d = 1'b1;
                  err_d  = 1'b1;
               end else if (req_we) begin
                  state_d = ST_WSET;
               end else begin
                  state_d = ST_RACT;
                  cnt_d   = CNT_W'(RD_CYCLES - 1);
               end
            end
         end
         ST_WSET: begin
            state_d = ST_WSTB;
            cnt_d   = CNT_W'(WR_STROBES - 1);
         end
         ST_WSTB: begin
            if (cnt_q == '0) state_d = ST_WREL;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_WREL: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         ST_RACT: begin
            if (cnt_q == '0) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         done_q  <= done_d;
         err_q   <= err_d;
      end
   end

endmodule

// File: rtl/xmb_datapath.sv
module xmb_datapath
   import xmb_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              capture,
   input  logic [ADDR_W-1:0] map_addr,
   input  logic [NUM_CE-1:0] sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr_q,
   output logic [NUM_CE-1:0] sel_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         sel_q   <= '0;
         wdata_q <= '0;
      end else if (load) begin
         addr_q  <= map_addr;
         sel_q   <= sel;
         wdata_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= din;
   end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
   import xmb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WIN_W      = 4,
   parameter int unsigned RD_CYCLES  = 2,
   parameter int unsigned WR_STROBES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_host,
   input  logic [1:0]        req_tgt,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sram_n,
   output logic              mem_flash_n,
   output logic              mem_xdev_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);

   generate
      if (WIN_W < 1 || WIN_W > ADDR_W) begin : g_chk_win
         $error("xmem_bus_ctrl: WIN_W must lie in 1..ADDR_W");
      end
      if (DATA_W < 1) begin : g_chk_data
         $error("xmem_bus_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic [NUM_CE-1:0] dec_sel, sel_q, ce_on;
   logic              dec_bad, load, capture;
   logic              ce_act, oe_act, we_act, drv_act;
   logic [ADDR_W-1:0] dec_addr;

   xmb_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_decode (
      .host     (req_host),
      .tgt      (req_tgt),
      .addr     (req_addr),
      .sel      (dec_sel),
      .bad      (dec_bad),
      .map_addr (dec_addr)
   );

   xmb_seq #(.RD_CYCLES(RD_CYCLES), .WR_STROBES(WR_STROBES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_bad   (dec_bad),
      .req_ready (req_ready),
      .load      (load),
      .capture   (capture),
      .ce_act    (ce_act),
      .oe_act    (oe_act),
      .we_act    (we_act),
      .drv_act   (drv_act),
      .done_q    (rsp_done),
      .err_q     (rsp_err)
   );

   xmb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .capture  (capture),
      .map_addr (dec_addr),
      .sel      (dec_sel),
      .wdata    (req_wdata),
      .din      (mem_din),
      .addr_q   (mem_addr),
      .sel_q    (sel_q),
      .wdata_q  (mem_dout),
      .rdata_q  (rsp_rdata)
   );

   assign ce_on       = sel_q & {NUM_CE{ce_act}};
   assign mem_sram_n  = ~ce_on[CE_SRAM];
   assign mem_flash_n = ~ce_on[CE_FLASH];
   assign mem_xdev_n  = ~ce_on[CE_XDEV];
   assign mem_oe_n    = ~oe_act;
   assign mem_we_n    = ~we_act;
   assign mem_dout_en = drv_act;

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WIN_W      = 4,
   parameter int unsigned RD_CYCLES  = 2,
   parameter int unsigned WR_STROBES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_host,
   input logic [1:0]        req_tgt,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_we,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sram_n,
   input logic              mem_flash_n,
   input logic              mem_xdev_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dout_en,
   input logic [DATA_W-1:0] mem_din
);

   logic any_ce;
   assign any_ce = ~(mem_sram_n & mem_flash_n & mem_xdev_n);

   a_r5_oe_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_en |-> mem_oe_n);

   a_r6_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~mem_sram_n, ~mem_flash_n, ~mem_xdev_n}) <= 1);

   a_r2_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (any_ce && mem_dout_en));

   a_r3_hold_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   a_r2_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (any_ce && mem_dout_en));

   a_r10_busy_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> any_ce);

   a_r8_window_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_xdev_n |-> (mem_addr >> WIN_W) == '0);

   a_r9_refuse_host: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_host && req_tgt == 2'd2)
      |=> (rsp_done && rsp_err && !any_ce && !mem_dout_en));

   a_r11_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_done || rsp_err) |-> $stable(rsp_rdata));

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
   .RD_CYCLES(RD_CYCLES), .WR_STROBES(WR_STROBES)
) u_chk (.*);

// File: tb/xmem_bus_ctrl_tb.sv
module xmem_bus_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_host = 1'b0;
   logic [1:0]  req_tgt = 2'd0;
   logic [16:0] req_addr = '0;
   logic        req_we = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done, rsp_err;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_sram_n, mem_flash_n, mem_xdev_n, mem_oe_n, mem_we_n;
   logic [7:0]  mem_dout;
   logic        mem_dout_en;
   logic [7:0]  mem_din = 8'hEE;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xmem_bus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_host(req_host), .req_tgt(req_tgt), .req_addr(req_addr), .req_we(req_we),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_sram_n(mem_sram_n),
      .mem_flash_n(mem_flash_n), .mem_xdev_n(mem_xdev_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_din(mem_din)
   );

   // bus-side device model: three separate byte stores
   byte unsigned dev_mem[int];
   byte unsigned shadow[int];

   function automatic byte unsigned dflt(input int t, input logic [16:0] a);
      return a[7:0] ^ 8'(t) ^ 8'h5A;
   endfunction

   function automatic int bus_tgt();
      if (!mem_sram_n)  return 0;
      if (!mem_flash_n) return 1;
      if (!mem_xdev_n)  return 2;
      return -1;
   endfunction

   always @(posedge mem_we_n) begin
      if (rst_n && bus_tgt() >= 0)
         dev_mem[bus_tgt() * 32'h20000 + int'(mem_addr)] = mem_dout;
   end

   always @(negedge clk) begin
      if (!mem_oe_n && bus_tgt() >= 0) begin
         int k;
         k = bus_tgt() * 32'h20000 + int'(mem_addr);
         mem_din <= dev_mem.exists(k) ? dev_mem[k] : dflt(bus_tgt(), mem_addr);
      end else begin
         mem_din <= 8'hEE;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   typedef struct { bit err; bit rd; logic [7:0] data; } rsp_t;
   rsp_t sb_q[$];
   logic [7:0] last_rd = 8'h00;

   // monitor: compare each completion with the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected completion", 32'd1, 32'd0);
         end else begin
            rsp_t e;
            e = sb_q.pop_front();
            chk(rsp_err == e.err, e.err ? "R9" : "R2", "rsp_err", 32'(rsp_err), 32'(e.err));
            chk(rsp_rdata == e.data, e.rd ? "R4" : "R11", "rsp_rdata", 32'(rsp_rdata), 32'(e.data));
         end
      end
   end

   task automatic do_req(input bit host, input bit [1:0] tgt, input bit [16:0] addr,
                         input bit we, input bit [7:0] wd, input bit poke);
      bit          bad;
      logic [16:0] maddr;
      logic [2:0]  ce_exp;
      int          n, key;
      rsp_t        e;
      string       tg;
      bad   = (tgt == 2'd3) || (host && tgt == 2'd2);
      maddr = (tgt == 2'd2) ? {13'd0, addr[3:0]} : addr;
      key   = int'(tgt) * 32'h20000 + int'(maddr);
      ce_exp = bad ? 3'b111 : ~(3'b001 << tgt);
      tg = bad ? "R9" : (tgt == 2'd2 ? "R8" : (we ? "R2" : "R4"));
      e.err = bad;
      e.rd  = !bad && !we;
      if (!bad && !we) last_rd = shadow.exists(key) ? shadow[key] : dflt(tgt, maddr);
      if (!bad && we)  shadow[key] = wd;
      e.data = last_rd;
      sb_q.push_back(e);
      n = bad ? 1 : (we ? 5 : 3);

      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_host = host; req_tgt = tgt; req_addr = addr;
      req_we = we; req_wdata = wd;
      for (int k = 1; k <= n + 1; k++) begin
         bit act, wlo, olo, drv;
         @(negedge clk);
         if (k == 1) begin
            req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd;
         end
         if (poke && k == 2) begin
            req_valid = 1'b1; req_tgt = 2'd1; req_we = 1'b0; req_host = 1'b0;
            req_addr = 17'h00042;
         end
         if (poke && k == 3) req_valid = 1'b0;
         act = !bad && k < n;
         wlo = we && act && (k == 2 || k == 3);
         olo = !we && act;
         drv = we && act;
         chk({mem_xdev_n, mem_flash_n, mem_sram_n} == (act ? ce_exp : 3'b111),
             bad ? "R9" : "R6", "chip enables",
             32'({mem_xdev_n, mem_flash_n, mem_sram_n}), 32'(act ? ce_exp : 3'b111));
         chk(mem_we_n == !wlo, we ? "R2" : "R5", "we_n", 32'(mem_we_n), 32'(!wlo));
         chk(mem_oe_n == !olo, we ? "R5" : "R4", "oe_n", 32'(mem_oe_n), 32'(!olo));
         chk(mem_dout_en == drv, we ? "R2" : "R5", "dout_en", 32'(mem_dout_en), 32'(drv));
         chk(rsp_done == (k == n), tg, "done pulse", 32'(rsp_done), 32'(k == n));
         if (act) begin
            chk(req_ready == 1'b0, "R10", "ready while busy", 32'(req_ready), 32'd0);
            chk(mem_addr == maddr, tgt == 2'd2 ? "R8" : (we ? "R3" : "R7"), "mem_addr",
                32'(mem_addr), 32'(maddr));
            if (we) chk(mem_dout == wd, "R3", "mem_dout", 32'(mem_dout), 32'(wd));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({mem_xdev_n, mem_flash_n, mem_sram_n, mem_oe_n, mem_we_n} == 5'b11111,
          "R1", "strobes in reset", 32'({mem_xdev_n, mem_flash_n, mem_sram_n, mem_oe_n, mem_we_n}), 32'h1F);
      chk(!mem_dout_en && !rsp_done && req_ready, "R1", "driver/done/ready in reset",
          32'({mem_dout_en, rsp_done, req_ready}), 32'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_sram_n && mem_oe_n && mem_we_n, "R1", "after reset",
          32'({req_ready, mem_sram_n, mem_oe_n, mem_we_n}), 32'hF);

      do_req(0, 2'd0, 17'h00012, 1, 8'hA5, 0);   // R2 SRAM write
      do_req(0, 2'd0, 17'h00012, 0, 8'h00, 0);   // R3 read back
      do_req(0, 2'd1, 17'h1FFFF, 1, 8'h3C, 0);   // R7 Flash top address
      do_req(0, 2'd1, 17'h1FFFF, 0, 8'h00, 0);
      do_req(0, 2'd0, 17'h1FFFF, 0, 8'h00, 0);   // R7 SRAM separate from Flash
      do_req(0, 2'd2, 17'h12345, 1, 8'h77, 0);   // R8 window maps to offset 5
      do_req(0, 2'd2, 17'h00005, 0, 8'h00, 0);   // R8 read back through window
      do_req(1, 2'd2, 17'h00005, 1, 8'h11, 0);   // R9 host write refused
      do_req(1, 2'd2, 17'h00003, 0, 8'h00, 0);   // R9 host read refused, R11 rdata kept
      do_req(0, 2'd3, 17'h00020, 0, 8'h00, 0);   // R9 reserved code
      do_req(1, 2'd0, 17'h0ABCD, 1, 8'hC3, 1);   // R10 busy poke ignored
      do_req(0, 2'd0, 17'h0ABCD, 0, 8'h00, 0);   // R5 read followed by write
      do_req(0, 2'd1, 17'h00100, 1, 8'h5E, 0);   // R11 rdata held across write
      chk(rsp_rdata == 8'hC3, "R11", "rdata after write", 32'(rsp_rdata), 32'hC3);
      do_req(0, 2'd2, 17'h1FFF5, 0, 8'h00, 0);   // R8 upper bits ignored
      do_req(0, 2'd1, 17'h00100, 0, 8'h00, 1);   // R3 flash data

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R10", "responses outstanding", 32'(sb_q.size()), 32'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule